// File: doc/BRIEF.md
# Error-event NMI aggregator with escalation watchdog

The block gathers a set of single-cycle error-event inputs into one non-maskable interrupt request for a processor. Every source owns a sticky pending flag; the request is the OR of the pending flags, gated by a global enable that software turns on once and cannot turn off again. Flags are acknowledged through a write-one-to-clear register, and a per-source enable register decides which events are recorded at all.

While the request is raised and any flag is still pending, an escalation counter advances by one on every clock. Acknowledging only some of the flags does not stop it. If it reaches the programmable period, the block drives a fixed-length pulse on its reset-request output. A small register port lets software set the controls, read the flags and read the running count.

Register map (3-bit address, registers start at bit 0): 0 control (bit 0 = global enable), 1 source enables, 2 pending flags, 3 flag acknowledge, 4 escalation period, 5 escalation count.

Top module: `nmi_escalator`

## Requirements
- R1: After reset, read-back shows global enable 0, every source enable 1, no pending flag, period equal to DEF_PERIOD and count 0. nmi_o and rst_req_o are low.
- R2: A one-cycle pulse on err_i[k] sets pending bit k (address 2) and it stays set. If bit k of the source enable register (address 1) is 0, the pulse is ignored.
- R3: Writing 1 to bit k of address 3 clears pending bit k and leaves the other bits alone. When a set and a clear of the same bit fall in the same cycle, the bit stays set. Reading address 3 returns 0.
- R4: nmi_o is high in the cycle after the edge at which the global enable is 1 and at least one flag is pending, and low otherwise.
- R5: Writing 1 to bit 0 of address 0 sets the global enable. Writing 0 has no effect. Only rst_i clears it.
- R6: Events that arrive while the global enable is 0 are still recorded as pending. nmi_o and the count stay at 0 until the enable is set.
- R7: While the enable is 1 and any flag is pending, the count (address 5) rises by one per clock up to the period. Otherwise it is 0. Writes to address 5 are ignored, and clearing only some flags does not stop or reset it.
- R8: When the count has reached the period while armed, rst_req_o goes high for exactly RST_PULSE cycles. This happens once per armed episode.
- R9: rd_data_o shows, one clock after the edge, the register selected by rd_addr_i at that edge, zero-extended. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Subsystem clock |
| rst_i | input | 1 | Synchronous active-high reset |
| err_i | input | N_SRC | Error-event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | DATA_W | Registered read data |
| nmi_o | output | 1 | Non-maskable interrupt request |
| rst_req_o | output | 1 | Escalation reset-request pulse |

## Verification
The bench builds the block with four sources, an 8-bit counter, a default period of 20 and a three-cycle reset pulse. The short period lets both the default-period and a reprogrammed period of 5 run out within a few dozen cycles. With only four sources, the bench can reach the cases of a disabled source, a partial acknowledge and a set-versus-clear collision on every bit. The 8-bit count would also let a test drive the period up to its full-scale value.

// File: rtl/nmi_esc_pkg.sv
package nmi_esc_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_SRCEN  = 3'd1,
    SEL_PEND   = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_PERIOD = 3'd4,
    SEL_COUNT  = 3'd5,
    SEL_RSV6   = 3'd6,
    SEL_RSV7   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/nmi_esc_flags.sv
module nmi_esc_flags #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [N_SRC-1:0] err_i,
  input  logic [N_SRC-1:0] srcen_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic [N_SRC-1:0] flag_o
);
  logic [N_SRC-1:0] flag_q;
  logic [N_SRC-1:0] flag_d;

  // set has priority over acknowledge (R2, R3)
  always_comb begin
    for (int k = 0; k < N_SRC; k++) begin
      if (err_i[k] && srcen_i[k])
        flag_d[k] = 1'b1;
      else if (ack_i[k])
        flag_d[k] = 1'b0;
      else
        flag_d[k] = flag_q[k];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) flag_q <= '0;
    else       flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/nmi_esc_wdog.sv
module nmi_esc_wdog #(
  parameter int N_SRC     = 8,
  parameter int CNT_W     = 16,
  parameter int RST_PULSE = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [N_SRC-1:0] flag_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nmi_o,
  output logic             rst_req_o
);
  localparam int PW = $clog2(RST_PULSE + 1);

  logic             armed;
  logic             trip;
  logic [CNT_W-1:0] cnt_q;
  logic             tripped_q;
  logic [PW-1:0]    pulse_q;
  logic             nmi_q;

  assign armed = en_i && (|flag_i);
  assign trip  = armed && (cnt_q >= period_i) && !tripped_q;

  // escalation counter: runs only while armed, parks at the period (R7)
  always_ff @(posedge clk_i) begin
    if (rst_i || !armed)
      cnt_q <= '0;
    else if (cnt_q < period_i)
      cnt_q <= cnt_q + 1'b1;
  end

  // one trip per armed episode (R8)
  always_ff @(posedge clk_i) begin
    if (rst_i || !armed) tripped_q <= 1'b0;
    else if (trip)       tripped_q <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                pulse_q <= '0;
    else if (trip)            pulse_q <= PW'(RST_PULSE);
    else if (pulse_q != '0)   pulse_q <= pulse_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) nmi_q <= 1'b0;
    else       nmi_q <= armed;
  end

  assign cnt_o     = cnt_q;
  assign nmi_o     = nmi_q;
  assign rst_req_o = (pulse_q != '0);
endmodule

// File: rtl/nmi_esc_regs.sv
module nmi_esc_regs
  import nmi_esc_pkg::*;
#(
  parameter int N_SRC      = 8,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter int DEF_PERIOD = 1000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  input  logic [N_SRC-1:0]  flag_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              en_o,
  output logic [N_SRC-1:0]  srcen_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [N_SRC-1:0]  ack_o,
  output logic [DATA_W-1:0] rd_data_o
);
  reg_sel_e          wr_sel;
  reg_sel_e          rd_sel;
  logic              en_q;
  logic [N_SRC-1:0]  srcen_q;
  logic [CNT_W-1:0]  period_q;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;

  assign wr_sel = reg_sel_e'(wr_addr_i);
  assign rd_sel = reg_sel_e'(rd_addr_i);

  // global enable: write-one-to-set, cleared by reset only (R5)
  always_ff @(posedge clk_i) begin
    if (rst_i)
      en_q <= 1'b0;
    else if (wr_en_i && wr_sel == SEL_CTRL && wr_data_i[0])
      en_q <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)
      srcen_q <= '1;
    else if (wr_en_i && wr_sel == SEL_SRCEN)
      srcen_q <= wr_data_i[N_SRC-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)
      period_q <= CNT_W'(DEF_PERIOD);
    else if (wr_en_i && wr_sel == SEL_PERIOD)
      period_q <= wr_data_i[CNT_W-1:0];
  end

  assign ack_o = (wr_en_i && wr_sel == SEL_ACK) ? wr_data_i[N_SRC-1:0] : '0;

  always_comb begin
    rd_d = '0;
    case (rd_sel)
      SEL_CTRL:   rd_d[0]          = en_q;
      SEL_SRCEN:  rd_d[N_SRC-1:0]  = srcen_q;
      SEL_PEND:   rd_d[N_SRC-1:0]  = flag_i;
      SEL_PERIOD: rd_d[CNT_W-1:0]  = period_q;
      SEL_COUNT:  rd_d[CNT_W-1:0]  = cnt_i;
      default:    rd_d             = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_q <= '0;
    else       rd_q <= rd_d;
  end

  assign en_o      = en_q;
  assign srcen_o   = srcen_q;
  assign period_o  = period_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/nmi_escalator.sv
module nmi_escalator #(
  parameter int N_SRC      = 8,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter int DEF_PERIOD = 1000,
  parameter int RST_PULSE  = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [N_SRC-1:0]  err_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              nmi_o,
  output logic              rst_req_o
);
  logic              en_q;
  logic [N_SRC-1:0]  srcen_q;
  logic [CNT_W-1:0]  period_q;
  logic [N_SRC-1:0]  ack_mask;
  logic [N_SRC-1:0]  flag_q;
  logic [CNT_W-1:0]  cnt_q;

  nmi_esc_regs #(
    .N_SRC(N_SRC), .CNT_W(CNT_W), .DATA_W(DATA_W), .DEF_PERIOD(DEF_PERIOD)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .flag_i    (flag_q),
    .cnt_i     (cnt_q),
    .en_o      (en_q),
    .srcen_o   (srcen_q),
    .period_o  (period_q),
    .ack_o     (ack_mask),
    .rd_data_o (rd_data_o)
  );

  nmi_esc_flags #(.N_SRC(N_SRC)) u_flags (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .err_i   (err_i),
    .srcen_i (srcen_q),
    .ack_i   (ack_mask),
    .flag_o  (flag_q)
  );

  nmi_esc_wdog #(
    .N_SRC(N_SRC), .CNT_W(CNT_W), .RST_PULSE(RST_PULSE)
  ) u_wdog (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (en_q),
    .flag_i    (flag_q),
    .period_i  (period_q),
    .cnt_o     (cnt_q),
    .nmi_o     (nmi_o),
    .rst_req_o (rst_req_o)
  );
endmodule

// File: rtl/nmi_escalator_chk.sv
module nmi_escalator_chk #(
  parameter int N_SRC  = 8,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              wr_en_i,
  input logic [2:0]        wr_addr_i,
  input logic              en_q,
  input logic [N_SRC-1:0]  flag_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              nmi_o,
  input logic              rst_req_o
);
  logic armed;
  logic ack_wr;
  assign armed  = en_q && (|flag_q);
  assign ack_wr = wr_en_i && (wr_addr_i == 3'd3);

  p_flag_fall_needs_ack_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (|($past(flag_q) & ~flag_q)) |-> $past(ack_wr));

  p_nmi_follows_armed_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    nmi_o |-> $past(armed));

  p_enable_sticky_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(en_q) |-> en_q);

  p_no_nmi_disabled_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_q |=> !nmi_o);

  p_count_idle_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !armed |=> (cnt_q == '0));

  p_trip_needs_armed_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rst_req_o) |-> $past(armed));
endmodule

bind nmi_escalator nmi_escalator_chk #(
  .N_SRC(N_SRC), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .en_q      (en_q),
  .flag_q    (flag_q),
  .cnt_q     (cnt_q),
  .nmi_o     (nmi_o),
  .rst_req_o (rst_req_o)
);

// File: tb/nmi_escalator_tb.sv
module nmi_escalator_tb;
  localparam int N   = 4;
  localparam int CW  = 8;
  localparam int DW  = 32;
  localparam int DP  = 20;
  localparam int RP  = 3;
  localparam int WD_LIMIT = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  err = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          nmi;
  logic          rst_req;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  nmi_escalator #(
    .N_SRC(N), .CNT_W(CW), .DATA_W(DW), .DEF_PERIOD(DP), .RST_PULSE(RP)
  ) u_dut (
    .clk_i(clk), .rst_i(rst), .err_i(err), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .nmi_o(nmi), .rst_req_o(rst_req)
  );

  // behavioural reference model
  bit          m_en, m_trip, m_nmi;
  bit [N-1:0]  m_src, m_flag;
  int          m_per, m_cnt, m_pulse;
  bit [DW-1:0] m_rd;

  function automatic bit [DW-1:0] model_read(int a);
    case (a)
      0: return DW'(m_en);
      1: return DW'(m_src);
      2: return DW'(m_flag);
      4: return DW'(m_per);
      5: return DW'(m_cnt);
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_src = '1; m_flag = '0; m_per = DP; m_cnt = 0;
      m_trip = 0; m_pulse = 0; m_nmi = 0; m_rd = '0;
    end else begin
      bit arm, fire;
      bit [N-1:0] clr;
      clr  = (wr_en && wr_addr == 3) ? wr_data[N-1:0] : '0;
      arm  = m_en && (m_flag != 0);
      fire = arm && (m_cnt >= m_per) && !m_trip;
      m_rd = model_read(int'(rd_addr));
      m_nmi = arm;
      if (!arm) begin m_cnt = 0; m_trip = 0; end
      else begin
        if (m_cnt < m_per) m_cnt = m_cnt + 1;
        if (fire) m_trip = 1;
      end
      if (fire) m_pulse = RP; else if (m_pulse > 0) m_pulse = m_pulse - 1;
      m_flag = (m_flag & ~clr) | (err & m_src);
      if (wr_en && wr_addr == 1) m_src = wr_data[N-1:0];
      if (wr_en && wr_addr == 4) m_per = int'(wr_data[CW-1:0]);
      if (wr_en && wr_addr == 0 && wr_data[0]) m_en = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (nmi !== m_nmi) begin
        fails++;
        $display("FAIL R4 cycle %0d nmi_o actual=%0b expected=%0b", cycles, nmi, m_nmi);
      end
      checks++;
      if (rst_req !== (m_pulse != 0)) begin
        fails++;
        $display("FAIL R8 cycle %0d rst_req_o actual=%0b expected=%0b", cycles, rst_req, m_pulse != 0);
      end
      checks++;
      if (rd_data !== m_rd) begin
        fails++;
        $display("FAIL R9 cycle %0d rd_data_o actual=%0h expected=%0h", cycles, rd_data, m_rd);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      summary();
    end
  end

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      wr_en = 0; err = '0;
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic pulse(logic [N-1:0] e);
    @(negedge clk); #1;
    err = e;
    @(negedge clk); #1;
    err = '0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] v);
    @(negedge clk); #1;
    rd_addr = 3'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst = 1;
    idle(4);
    rst = 0;
  endtask

  initial begin
    logic [DW-1:0] v, v2;
    int hi;
    do_reset();
    // R1 reset state
    rd(0, v); check("R1 enable", v, 0);
    rd(1, v); check("R1 source enables", v, 4'hF);
    rd(2, v); check("R1 pending", v, 0);
    rd(4, v); check("R1 period", v, DP);
    rd(5, v); check("R1 count", v, 0);
    check("R1 nmi_o", DW'(nmi), 0);
    check("R1 rst_req_o", DW'(rst_req), 0);

    // R6 events recorded while disabled, no nmi, no counting
    pulse(4'b0010);
    idle(3);
    rd(2, v); check("R6 pending while disabled", v, 4'b0010);
    check("R6 nmi_o held low", DW'(nmi), 0);
    rd(5, v); check("R6 count held at zero", v, 0);

    // R5 writing 0 does nothing, writing 1 sets
    wr(0, 0);
    rd(0, v); check("R5 write 0 ignored", v, 0);
    wr(0, 1);
    idle(2);
    check("R4 nmi_o raised", DW'(nmi), 1);
    wr(0, 0);
    rd(0, v); check("R5 enable not clearable", v, 1);

    // R7 count advances, writes to it ignored
    rd(5, v);
    wr(5, 0);
    rd(5, v2); check("R7 count advances after write", DW'(v2 > v), 1);

    // R7 partial clear does not stop counting; R3 clear all drops nmi
    pulse(4'b0100);
    wr(3, 4'b0010);
    rd(2, v); check("R3 only acked bit cleared", v, 4'b0100);
    check("R7 nmi stays after partial ack", DW'(nmi), 1);
    rd(5, v); rd(5, v2); check("R7 count continues after partial ack", DW'(v2 >= v && v2 != 0), 1);
    wr(3, 4'b0100);
    idle(2);
    check("R4 nmi_o dropped after full ack", DW'(nmi), 0);
    rd(5, v); check("R7 count zero when idle", v, 0);

    // R3 set wins over clear in the same cycle
    @(negedge clk); #1;
    err = 4'b0001; wr_en = 1; wr_addr = 3; wr_data = 4'b0001;
    @(negedge clk); #1;
    err = '0; wr_en = 0;
    rd(2, v); check("R3 set beats clear", v, 4'b0001);
    rd(3, v); check("R3 ack address reads zero", v, 0);
    wr(3, 4'hF);
    idle(2);

    // R2 disabled source ignored
    wr(1, 4'b0111);
    pulse(4'b1000);
    rd(2, v); check("R2 disabled source ignored", v, 0);
    check("R2 no nmi from disabled source", DW'(nmi), 0);
    wr(1, 4'hF);
    rd(6, v); check("R9 unused address reads zero", v, 0);

    // R8 escalation with period 5
    wr(4, 5);
    pulse(4'b0001);
    hi = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (rst_req) hi++;
    end
    check("R8 reset pulse length once per episode", hi, RP);
    rd(5, v); check("R8 count parked at period", v, 5);
    wr(3, 4'hF);
    idle(2);

    // R8 escalation at default period after block reset, R1/R5 reset clears
    do_reset();
    rd(0, v); check("R5 reset clears enable", v, 0);
    rd(4, v); check("R1 period restored", v, DP);
    wr(0, 1);
    pulse(4'b1000);
    hi = 0;
    for (int i = 0; i < DP + 10; i++) begin
      @(negedge clk);
      if (rst_req) hi++;
    end
    check("R8 default-period reset pulse", hi, RP);
    idle(3);
    summary();
  end
endmodule